// File: doc/BRIEF.md
# Configuration Bank Write Guard

This block sits in front of a bank of configuration registers and decides, on every host byte write, whether that write may reach the bank. A lock flag gates the bank. While the flag is set, writes aimed at guarded addresses are dropped, and a sticky violation flag records the attempt. The host clears the flag with a four-byte key typed into the status address. Any single wrong byte spoils the key. The host can poll the lock flag and send the key again.

Relocking needs no help from software. A one-second tick decrements a countdown whenever the bank is open. The bank closes when the countdown runs out. After reset the bank starts open and the countdown runs from a longer power-on value. After a key, it runs from a short value. The host can also close the bank at once with a single lock byte.

Top module: `wr_guard`

## Requirements
- R1: Four consecutive writes to the status address (address 0) carrying 0x00, 0x40, 0xC0 and 0x80, in that order, clear `locked` from the clock edge that samples the fourth byte.
- R2: A status write whose byte does not match the next expected key byte sends the key tracker back to its first step. A write to any other address also sends it back to the first step. A mismatching byte of 0x00 counts as the first key byte, so the tracker resumes at its second step.
- R3: A status write of 0x80 while unlocked, that does not complete the key, sets `locked` at the next edge.
- R4: After a completed key, the bank relocks on the UNLOCK_SECS-th `sec_tick` pulse (default 2). The edge that samples that pulse sets `locked`.
- R5: Out of reset the bank is unlocked and relocks on the POR_SECS-th `sec_tick` pulse (default 15).
- R6: `bank_we` is combinational. It is high in the same cycle as a write to a guarded address (1 to 15) while unlocked. A write to the status address never raises it.
- R7: A guarded write while locked leaves `bank_we` low. It sets `viol` at the next edge, and `viol` stays set until reset.
- R8: A key completed while already unlocked keeps the bank open and reloads the countdown to UNLOCK_SECS.
- R9: During and right after reset, `locked` and `viol` are both 0.
- R10: When a tick arrives in the same cycle as the final key byte, the key wins. The countdown starts fresh at UNLOCK_SECS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-on) |
| wr_en | input | 1 | Host byte write strobe |
| wr_addr | input | ADDR_W | Write address; STAT_ADDR is the status register |
| wr_data | input | 8 | Write byte |
| sec_tick | input | 1 | One-cycle pulse once per second |
| locked | output | 1 | Protection flag, readable by the host for polling |
| bank_we | output | 1 | Write enable passed to the guarded bank |
| viol | output | 1 | Sticky flag for a write attempted while locked |

## Verification
The hardest cases to reach are the collisions. One is a key completed while the bank is already open, which must reload the countdown and not close the bank. Another is a final key byte landing in the same cycle as a tick. The stimulus brings out the first case by spending one tick of a fresh unlock and then replaying the key, so only one tick of margin would remain if the reload were missing. It brings out the second by driving the tick and the fourth byte together. A reference model in the bench follows the tracker through broken keys, including a key interrupted by a guarded write, and predicts every cycle's outputs.

// File: rtl/wr_guard.sv
module wr_guard #(
  parameter int ADDR_W      = 4,
  parameter int STAT_ADDR   = 0,
  parameter int PROT_LO     = 1,
  parameter int PROT_HI     = 15,
  parameter int UNLOCK_SECS = 2,
  parameter int POR_SECS    = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              sec_tick,
  output logic              locked,
  output logic              bank_we,
  output logic              viol
);

  localparam int TMR_MAX = (POR_SECS > UNLOCK_SECS) ? POR_SECS : UNLOCK_SECS;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] LO_A   = ADDR_W'(PROT_LO);
  localparam logic [ADDR_W-1:0] HI_A   = ADDR_W'(PROT_HI);

  logic [1:0]       step;
  logic [TMR_W-1:0] tmr;
  logic [7:0]       want;

  always_comb begin
    case (step)
      2'd0:    want = 8'h00;
      2'd1:    want = 8'h40;
      2'd2:    want = 8'hC0;
      default: want = 8'h80;
    endcase
  end

  wire stat_wr  = wr_en && (wr_addr == STAT_A);
  wire prot_hit = wr_en && (wr_addr >= LO_A) && (wr_addr <= HI_A) && !stat_wr;
  wire key_ok   = stat_wr && (wr_data == want);
  wire key_done = key_ok && (step == 2'd3);
  wire lock_req = stat_wr && (wr_data == 8'h80) && !key_done;

  assign bank_we = prot_hit && !locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step <= 2'd0;
    else if (stat_wr) begin
      if (key_ok)                step <= key_done ? 2'd0 : step + 2'd1;
      else if (wr_data == 8'h00) step <= 2'd1;
      else                       step <= 2'd0;
    end else if (wr_en)          step <= 2'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b0;
      tmr    <= TMR_W'(POR_SECS);
    end else if (key_done) begin
      locked <= 1'b0;
      tmr    <= TMR_W'(UNLOCK_SECS);
    end else if (!locked) begin
      if (lock_req) locked <= 1'b1;
      else if (sec_tick) begin
        if (tmr <= TMR_W'(1)) locked <= 1'b1;
        else                  tmr    <= tmr - TMR_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  viol <= 1'b0;
    else if (prot_hit && locked) viol <= 1'b1;
  end

  AST_UNLOCK_BY_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(stat_wr && wr_data == 8'h80 && step == 2'd3)); // R1
  AST_LOCK_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && stat_wr && wr_data == 8'h80 && step != 2'd3) |=> locked); // R3
  AST_RELOCK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(sec_tick || (stat_wr && wr_data == 8'h80))); // R4
  AST_TMR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> (tmr != '0 && tmr <= TMR_W'(TMR_MAX))); // R5
  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> viol); // R7
  AST_VIOL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(viol) |-> $past(locked && wr_en && !bank_we)); // R7

endmodule

// File: tb/wr_guard_tb.sv
module wr_guard_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       sec_tick = 1'b0;
  logic       locked, bank_we, viol;

  always #5 clk = ~clk;

  wr_guard dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
                  .wr_data(wr_data), .sec_tick(sec_tick), .locked(locked),
                  .bank_we(bank_we), .viol(viol));

  typedef struct { logic we; logic lk; logic vi; string tag; } item_t;
  item_t q[$];
  int n_chk = 0, n_bad = 0;

  logic m_lk, m_vi;
  int   m_step, m_tmr;

  function automatic logic [7:0] key_byte(int s);
    case (s) 0: return 8'h00; 1: return 8'h40; 2: return 8'hC0; default: return 8'h80; endcase
  endfunction

  task automatic drive(input logic w, input logic [3:0] a, input logic [7:0] d,
                       input logic t, input string tag);
    item_t it;
    logic st, prot, done;
    @(negedge clk);
    wr_en = w; wr_addr = a; wr_data = d; sec_tick = t;
    st   = w && (a == 4'd0);
    prot = w && (a != 4'd0);
    it.we = prot && !m_lk; it.lk = m_lk; it.vi = m_vi; it.tag = tag;
    q.push_back(it);
    done = st && d == 8'h80 && m_step == 3;
    if (prot && m_lk) m_vi = 1'b1;
    if (done) begin m_lk = 1'b0; m_tmr = 2; end
    else if (!m_lk) begin
      if (st && d == 8'h80) m_lk = 1'b1;
      else if (t) begin
        if (m_tmr <= 1) m_lk = 1'b1; else m_tmr--;
      end
    end
    if (st) begin
      if (d == key_byte(m_step)) m_step = (m_step == 3) ? 0 : m_step + 1;
      else if (d == 8'h00)       m_step = 1;
      else                       m_step = 0;
    end else if (w) m_step = 0;
  endtask

  task automatic idle(input logic t, input string tag);
    drive(1'b0, 4'd0, 8'h00, t, tag);
  endtask

  task automatic key(input logic tick_last, input string tag);
    drive(1'b1, 4'd0, 8'h00, 1'b0, tag);
    drive(1'b1, 4'd0, 8'h40, 1'b0, tag);
    drive(1'b1, 4'd0, 8'hC0, 1'b0, tag);
    drive(1'b1, 4'd0, 8'h80, tick_last, tag);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk); #2;
      if (q.size() > 0) begin
        it = q.pop_front();
        n_chk++;
        if (bank_we !== it.we || locked !== it.lk || viol !== it.vi) begin
          n_bad++;
          $display("FAIL %s: we/lk/vi actual %b%b%b expected %b%b%b",
                   it.tag, bank_we, locked, viol, it.we, it.lk, it.vi);
        end
      end
    end
  end

  initial begin : watchdog
    #1000000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    m_lk = 1'b0; m_vi = 1'b0; m_step = 0; m_tmr = 15;
    repeat (3) @(negedge clk);
    n_chk++;
    if (locked !== 1'b0 || viol !== 1'b0) begin
      n_bad++;
      $display("FAIL R9: lk/vi actual %b%b expected 00", locked, viol);
    end
    rst_n = 1'b1;
    idle(1'b0, "R9");
    for (int i = 0; i < 14; i++) idle(1'b1, "R5");
    drive(1'b1, 4'd5, 8'hAA, 1'b0, "R6");
    drive(1'b1, 4'd0, 8'h11, 1'b0, "R6");
    idle(1'b1, "R5");
    idle(1'b0, "R5");
    drive(1'b1, 4'd7, 8'h33, 1'b0, "R7");
    drive(1'b1, 4'd0, 8'h40, 1'b0, "R7");
    idle(1'b0, "R7");
    key(1'b0, "R1");
    drive(1'b1, 4'd15, 8'h01, 1'b0, "R1");
    idle(1'b1, "R4");
    idle(1'b0, "R4");
    idle(1'b1, "R4");
    idle(1'b0, "R4");
    drive(1'b1, 4'd0, 8'h00, 1'b0, "R2");
    drive(1'b1, 4'd0, 8'h40, 1'b0, "R2");
    drive(1'b1, 4'd0, 8'h55, 1'b0, "R2");
    drive(1'b1, 4'd0, 8'hC0, 1'b0, "R2");
    drive(1'b1, 4'd0, 8'h80, 1'b0, "R2");
    idle(1'b0, "R2");
    drive(1'b1, 4'd0, 8'h00, 1'b0, "R2");
    key(1'b0, "R2");
    idle(1'b0, "R2");
    drive(1'b1, 4'd0, 8'h80, 1'b0, "R3");
    idle(1'b0, "R3");
    drive(1'b1, 4'd0, 8'h00, 1'b0, "R2");
    drive(1'b1, 4'd0, 8'h40, 1'b0, "R2");
    drive(1'b1, 4'd3, 8'h00, 1'b0, "R2");
    drive(1'b1, 4'd0, 8'hC0, 1'b0, "R2");
    drive(1'b1, 4'd0, 8'h80, 1'b0, "R2");
    idle(1'b0, "R2");
    key(1'b0, "R8");
    idle(1'b1, "R8");
    key(1'b0, "R8");
    idle(1'b1, "R8");
    drive(1'b1, 4'd2, 8'h44, 1'b0, "R8");
    idle(1'b1, "R8");
    idle(1'b0, "R8");
    key(1'b1, "R10");
    idle(1'b1, "R10");
    idle(1'b0, "R10");
    idle(1'b1, "R10");
    idle(1'b0, "R10");
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule